// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is an 8-bit arithmetic and logic unit that owns an accumulator and a five-flag status byte. A caller presents an operation code and an operand byte and raises a one-cycle strobe. One clock later the block has updated the accumulator and the flag byte, and it raises a done pulse. The operand byte may come from a register or from an immediate field; the block treats both the same way. The caller handles instruction decoding, register selection and memory access.

The operations are add, subtract, increment, decrement, AND, OR, XOR, compare and rotate-left. Every operation except compare writes its result back to the accumulator. Each operation sets or clears the flags according to its own rules. The flags are sign, zero, half (nibble) carry, parity and carry, and each sits at a fixed bit position of the status byte.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `acc`, `flags` and `done` are cleared to 0.
- R2: A strobe on `start` at a clock edge gives `done`=1 during the following cycle only. With `start` low, `acc` and `flags` hold their values and `done` is 0.
- R3: Op code 0 (add) writes acc+opd and op code 1 (subtract) writes acc-opd, both modulo 256. Carry is the carry out of bit 7 for add and the borrow for subtract.
- R4: Op code 2 (increment) writes acc+1 and op code 3 (decrement) writes acc-1, both wrapping. `opd` is ignored and carry keeps its previous value.
- R5: Op codes 4, 5 and 6 write acc AND opd, acc OR opd and acc XOR opd. Each clears both carry and half carry.
- R6: Op code 7 (compare) computes acc-opd and sets all five flags as subtract does, but leaves `acc` unchanged. Carry is 1 exactly when opd > acc as unsigned values.
- R7: Op code 8 (rotate-left) moves each accumulator bit up by one and copies bit 7 into both bit 0 and carry. It leaves the other four flags unchanged.
- R8: Flag byte layout: sign = bit 7, zero = bit 6, half carry = bit 4, parity = bit 2, carry = bit 0. Bits 5, 3 and 1 always read 0.
- R9: For op codes 0 to 7, sign is bit 7 of the result and zero is set when the result is 0. Parity is set when the result has an even number of 1 bits.
- R10: Half carry is the carry out of bit 3 for add and increment. For subtract, compare and decrement it is 1 when the low nibble of the accumulator is below the low nibble of the subtrahend (opd, or 1 for decrement).
- R11: Op codes 9 to 15 still produce the `done` pulse but change neither `acc` nor `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 4 | Operation code |
| opd | input | 8 | Operand byte |
| acc | output | 8 | Accumulator value (registered) |
| flags | output | 8 | Status byte (registered) |
| done | output | 1 | Completion pulse, one cycle after `start` |

## Verification
The bench builds the block with its defaults: an 8-bit data path, a 4-bit op code and a 4-bit nibble for half carry. This size reaches every unsigned wrap and every nibble-borrow edge with small literal operands. The vector sequence chains operations so that each step starts from the state left by the previous one. This covers add overflow to zero, increment from 0xFF, decrement from 0x00, compare with an equal and a larger operand, and rotates with both values of bit 7.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_ROL = 4'd8
  } alu_op_e;

  localparam int FLAG_W = 8;
  localparam int FB_S   = 7;
  localparam int FB_Z   = 6;
  localparam int FB_AC  = 4;
  localparam int FB_P   = 2;
  localparam int FB_CY  = 0;
  localparam logic [3:0] OP_LAST = 4'd8;

  function automatic logic op_is_arith(input logic [3:0] c);
    return (c == OP_ADD) || (c == OP_SUB) || (c == OP_INC) ||
           (c == OP_DEC) || (c == OP_CMP);
  endfunction
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              cy,
  output logic              ac
);
  localparam logic [DATA_W:0] ONE_W = (DATA_W+1)'(1);
  localparam logic [NIB_W:0]  ONE_N = (NIB_W+1)'(1);

  logic [DATA_W:0] wide;
  logic [NIB_W:0]  nib;

  always_comb begin
    wide = '0;
    nib  = '0;
    case (op)
      OP_ADD: begin
        wide = {1'b0, a} + {1'b0, b};
        nib  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]};
      end
      OP_SUB, OP_CMP: begin
        wide = {1'b0, a} - {1'b0, b};
        nib  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]};
      end
      OP_INC: begin
        wide = {1'b0, a} + ONE_W;
        nib  = {1'b0, a[NIB_W-1:0]} + ONE_N;
      end
      OP_DEC: begin
        wide = {1'b0, a} - ONE_W;
        nib  = {1'b0, a[NIB_W-1:0]} - ONE_N;
      end
      default: begin
        wide = '0;
        nib  = '0;
      end
    endcase
  end

  assign res = wide[DATA_W-1:0];
  assign cy  = wide[DATA_W];
  assign ac  = nib[NIB_W];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              rot_cy
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_ROL:  res = {a[DATA_W-2:0], a[DATA_W-1]};
      default: res = '0;
    endcase
  end

  assign rot_cy = a[DATA_W-1];
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] res,
  input  logic              ar_cy,
  input  logic              ar_ac,
  input  logic              rot_cy,
  input  logic [FLAG_W-1:0] cur,
  output logic [FLAG_W-1:0] nxt
);
  logic s_b, z_b, p_b;

  assign s_b = res[DATA_W-1];
  assign z_b = (res == '0);
  assign p_b = ~^res;

  always_comb begin
    nxt = '0;
    nxt[FB_S]  = cur[FB_S];
    nxt[FB_Z]  = cur[FB_Z];
    nxt[FB_AC] = cur[FB_AC];
    nxt[FB_P]  = cur[FB_P];
    nxt[FB_CY] = cur[FB_CY];
    case (op)
      OP_ADD, OP_SUB, OP_CMP: begin
        nxt[FB_S]  = s_b;
        nxt[FB_Z]  = z_b;
        nxt[FB_P]  = p_b;
        nxt[FB_AC] = ar_ac;
        nxt[FB_CY] = ar_cy;
      end
      OP_INC, OP_DEC: begin
        nxt[FB_S]  = s_b;
        nxt[FB_Z]  = z_b;
        nxt[FB_P]  = p_b;
        nxt[FB_AC] = ar_ac;
      end
      OP_AND, OP_OR, OP_XOR: begin
        nxt[FB_S]  = s_b;
        nxt[FB_Z]  = z_b;
        nxt[FB_P]  = p_b;
        nxt[FB_AC] = 1'b0;
        nxt[FB_CY] = 1'b0;
      end
      OP_ROL: nxt[FB_CY] = rot_cy;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OP_W   = 4,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opd,
  output logic [DATA_W-1:0] acc,
  output logic [FLAG_W-1:0] flags,
  output logic              done
);
  logic [DATA_W-1:0] acc_q;
  logic [FLAG_W-1:0] flg_q;
  logic              done_q;

  logic [3:0]        op4;
  logic [DATA_W-1:0] ar_res, lg_res, res;
  logic              ar_cy, ar_ac, rot_cy;
  logic [FLAG_W-1:0] flg_nxt;
  logic              known, wr_acc;

  assign op4    = 4'(op);
  assign known  = (op <= OP_W'(OP_LAST));
  assign wr_acc = start && known && (op4 != OP_CMP);

  acc_alu_arith #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
    .op(op4), .a(acc_q), .b(opd), .res(ar_res), .cy(ar_cy), .ac(ar_ac)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op(op4), .a(acc_q), .b(opd), .res(lg_res), .rot_cy(rot_cy)
  );

  assign res = op_is_arith(op4) ? ar_res : lg_res;

  acc_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .op(op4), .res(res), .ar_cy(ar_cy), .ar_ac(ar_ac), .rot_cy(rot_cy),
    .cur(flg_q), .nxt(flg_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start;
      if (wr_acc)
        acc_q <= res;
      if (start && known)
        flg_q <= flg_nxt;
    end
  end

  assign acc   = acc_q;
  assign flags = flg_q;
  assign done  = done_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OP_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [OP_W-1:0]   op,
  input logic [DATA_W-1:0] opd,
  input logic [DATA_W-1:0] acc,
  input logic [FLAG_W-1:0] flags,
  input logic              done
);
  localparam logic [FLAG_W-1:0] SPARE = 8'b0010_1010;

  a_r2_done_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!done && $stable(acc) && $stable(flags)));

  a_r8_spare_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (flags & SPARE) == '0);

  a_r6_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (start && op == OP_W'(OP_CMP)) |=> $stable(acc));

  a_r4_incdec_keep_carry: assert property (@(posedge clk) disable iff (rst)
    (start && (op == OP_W'(OP_INC) || op == OP_W'(OP_DEC)))
      |=> (flags[FB_CY] == $past(flags[FB_CY])));

  a_r5_logic_clears_carry: assert property (@(posedge clk) disable iff (rst)
    (start && (op == OP_W'(OP_AND) || op == OP_W'(OP_OR) || op == OP_W'(OP_XOR)))
      |=> (!flags[FB_CY] && !flags[FB_AC]));

  a_r9_zero_tracks_acc: assert property (@(posedge clk) disable iff (rst)
    (start && op < OP_W'(OP_CMP)) |=> (flags[FB_Z] == (acc == '0)));

  a_r11_unknown_no_change: assert property (@(posedge clk) disable iff (rst)
    (start && op > OP_W'(OP_LAST)) |=> ($stable(acc) && $stable(flags)));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .opd(opd),
  .acc(acc), .flags(flags), .done(done)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  localparam int PERIOD = 10;
  localparam int NV = 17;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] opd = '0;
  logic [7:0] acc, flags;
  logic       done;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  // {op, opd, expected acc, expected flags}; each step starts from the previous state
  localparam logic [27:0] VEC [NV] = '{
    {4'd0, 8'h3A, 8'h3A, 8'h04},  // R3 add
    {4'd0, 8'hC6, 8'h00, 8'h55},  // R3 R10 add wraps to zero
    {4'd0, 8'h7F, 8'h7F, 8'h00},  // R9 odd parity
    {4'd2, 8'hAA, 8'h80, 8'h90},  // R4 inc, nibble carry
    {4'd1, 8'h81, 8'hFF, 8'h95},  // R3 R10 sub borrow
    {4'd3, 8'h00, 8'hFE, 8'h81},  // R4 dec keeps carry
    {4'd4, 8'h0F, 8'h0E, 8'h00},  // R5 and
    {4'd5, 8'hF0, 8'hFE, 8'h80},  // R5 or
    {4'd6, 8'hFE, 8'h00, 8'h44},  // R5 xor
    {4'd5, 8'h96, 8'h96, 8'h84},  // R9 even parity, sign
    {4'd7, 8'h96, 8'h96, 8'h44},  // R6 compare equal
    {4'd7, 8'hA0, 8'h96, 8'h85},  // R6 compare larger operand
    {4'd8, 8'h00, 8'h2D, 8'h85},  // R7 rotate bit7=1
    {4'd8, 8'h00, 8'h5A, 8'h84},  // R7 rotate bit7=0
    {4'd1, 8'h5A, 8'h00, 8'h44},  // R3 sub to zero
    {4'd3, 8'h00, 8'hFF, 8'h94},  // R4 R10 dec from zero
    {4'd2, 8'h00, 8'h00, 8'h54}   // R4 R10 inc from FF
  };

  acc_alu uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .opd(opd),
    .acc(acc), .flags(flags), .done(done)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [7:0] d);
    @(negedge clk);
    start = 1'b1; op = c; opd = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "acc after reset", acc, 8'h00);
    check("R1", "flags after reset", flags, 8'h00);
    check("R1", "done after reset", {7'd0, done}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][27:24], VEC[i][23:16]);
      check("R3-R10 vec acc", $sformatf("step %0d", i), acc, VEC[i][15:8]);
      check("R8 R9 vec flags", $sformatf("step %0d", i), flags, VEC[i][7:0]);
      check("R2", "done pulse", {7'd0, done}, 8'h01);
    end

    // R2: done lasts one cycle; idle input does nothing
    op = 4'd0; opd = 8'hFF;
    @(negedge clk);
    check("R2", "done drops", {7'd0, done}, 8'h00);
    check("R2", "idle acc", acc, 8'h00);
    check("R2", "idle flags", flags, 8'h54);

    // R11: unused op code
    issue(4'hF, 8'h12);
    check("R11", "acc unchanged", acc, 8'h00);
    check("R11", "flags unchanged", flags, 8'h54);
    check("R11", "done still pulses", {7'd0, done}, 8'h01);
    issue(4'h9, 8'h77);
    check("R11", "acc unchanged op9", acc, 8'h00);

    // R6: compare smaller operand leaves acc, clears carry
    issue(4'd0, 8'h50);
    issue(4'd7, 8'h21);
    check("R6", "cmp acc kept", acc, 8'h50);
    check("R6 R10", "cmp flags", flags, 8'h10);

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "acc on reset", acc, 8'h00);
    check("R1", "flags on reset", flags, 8'h00);
    rst = 1'b0;

    finish_run();
  end
endmodule